// File: doc/BRIEF.md
# Karatsuba Carry-Less GHASH Engine

This block computes the GHASH function used for authenticated encryption. It multiplies a 128-bit accumulator by a hash key in GF(2^128) and returns the product. The multiply is split into three 64x64 carry-less products using Karatsuba. The partial results are recombined and then reduced with two 64-bit folds by a fixed constant. Because the fold works on the upper half of the raw product, the key is stored pre-divided by x (the "twisted" form). That form is computed once, when the key is loaded.

Software or a host engine loads the hash key through a valid/ready key port. Loading a key clears the accumulator. It then streams 128-bit blocks through a second valid/ready port. Each accepted block is XORed into the accumulator and the sum is multiplied by the key. The new accumulator appears on `acc_o` with a one-cycle `done_o` pulse, so a message of any length is hashed by sending its blocks one after another.

The three carry-less multipliers are chosen by a parameter. One variant is a registered single-cycle array. The other is a multi-cycle shift-XOR unit that handles `STEP` bits of the first operand per cycle.

Top module: `ghash_karatsuba`

## Requirements
- R1: After reset `acc_o` is zero, `done_o` is low, `key_ready_o` is high and `blk_ready_o` is low, because no key is loaded yet.
- R2: A key handshake (`key_valid_i` and `key_ready_o` high at a clock edge) stores `key_i` as the hash key. It also makes `acc_o` zero from that edge on.
- R3: A block handshake replaces the accumulator with (acc XOR `blk_i`) times H in GF(2^128). Bit 127 of a 128-bit word is the coefficient of x^0 and bit 0 is the coefficient of x^127. The modulus is x^128+x^7+x^2+x+1.
- R4: R3 holds both for keys with bit 127 set and for keys with bit 127 clear.
- R5: Successive blocks chain: each multiply starts from the accumulator left by the previous block, which hashes a multi-block message.
- R6: With `SERIAL`=0, `acc_o` takes the new value on the first clock edge after the accepting edge, and `done_o` is high for that one cycle. With `SERIAL`=1 the same happens 64/`STEP`+1 edges after acceptance.
- R7: While a multiply is in flight, `key_ready_o` and `blk_ready_o` are low. A key offered during that time is taken only after the result is out, so the in-flight block uses the old key.
- R8: While `key_valid_i` is high, `blk_ready_o` is low, so a key offered together with a block is taken first and the block is multiplied by the new key.
- R9: `done_o` is never high on two consecutive cycles. `acc_o` changes only together with a `done_o` pulse or right after a key handshake.
- R10: The identity key (only bit 127 set) returns the block unchanged. A zero block on a zero accumulator gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_valid_i | input | 1 | Hash key offered |
| key_ready_o | output | 1 | Key can be taken (no multiply in flight) |
| key_i | input | 128 | Hash key H |
| blk_valid_i | input | 1 | Data block offered |
| blk_ready_o | output | 1 | Block can be taken |
| blk_i | input | 128 | Data block |
| acc_o | output | 128 | Current accumulator |
| done_o | output | 1 | One-cycle pulse when a new accumulator is out |

## Verification
Fixed blocks are sent with the identity key and with a zero block. These expose errors in bit order and in the final fold, since the expected output equals the input or zero. Random keys are then tried with bit 127 clear and with it set, which drives both branches of the key twist. Each is used on chains of random blocks, so a slip in Karatsuba recombination or in the middle fold builds up over the chain. Key and block offers are also made during a multiply and in the same cycle, which shows whether the key used belongs to the right block.

// File: rtl/ghash_pkg.sv
package ghash_pkg;
  localparam int unsigned LANE_W = 64;
  localparam int unsigned BLK_W  = 2 * LANE_W;
  localparam int unsigned NUM_PROD = 3;

  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [BLK_W-1:0]  blk_t;

  typedef struct packed {
    lane_t hi;
    lane_t lo;
  } pair_t;

  // fold constant: taps 63, 62, 57 of a lane
  localparam lane_t RED_K = lane_t'(8'hC2) << (LANE_W - 8);

  function automatic blk_t clmul(input lane_t a, input lane_t b);
    blk_t r;
    r = '0;
    for (int i = 0; i < int'(LANE_W); i++) begin
      if (a[i]) r ^= blk_t'(b) << i;
    end
    return r;
  endfunction
endpackage

// File: rtl/ghash_key_twist.sv
module ghash_key_twist
  import ghash_pkg::*;
(
  input  blk_t  key_i,
  output blk_t  twist_o,
  output lane_t sum_o
);
  localparam blk_t TWIST_POLY = {RED_K, lane_t'(1)};

  logic  top_bit;
  blk_t  shifted;
  pair_t tw;

  always_comb begin
    top_bit = key_i[BLK_W-1];
    shifted = key_i << 1;
    tw      = shifted ^ (top_bit ? TWIST_POLY : '0);
  end

  assign twist_o = tw;
  // Karatsuba middle operand precomputed at load
  assign sum_o   = tw.hi ^ tw.lo;
endmodule

// File: rtl/ghash_clmul_unit.sv
module ghash_clmul_unit
  import ghash_pkg::*;
#(
  parameter bit          SERIAL = 1'b0,
  parameter int unsigned STEP   = 8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  lane_t a_i,
  input  lane_t b_i,
  output logic  done_o,
  output blk_t  prod_o
);
  localparam int unsigned ITERS = LANE_W / STEP;
  localparam int unsigned CNT_W = (ITERS > 1) ? $clog2(ITERS) : 1;

  generate
    if (!SERIAL) begin : g_array
      blk_t prod_q;
      logic done_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          prod_q <= '0;
          done_q <= 1'b0;
        end else begin
          done_q <= start_i;
          if (start_i) prod_q <= clmul(a_i, b_i);
        end
      end

      assign prod_o = prod_q;
      assign done_o = done_q;
    end else begin : g_shift
      lane_t             a_q;
      blk_t              b_q;
      blk_t              acc_q;
      blk_t              step_x;
      logic [CNT_W-1:0]  cnt_q;
      logic              run_q;
      logic              done_q;

      always_comb begin
        step_x = '0;
        for (int s = 0; s < int'(STEP); s++) begin
          if (a_q[s]) step_x ^= b_q << s;
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          a_q    <= '0;
          b_q    <= '0;
          acc_q  <= '0;
          cnt_q  <= '0;
          run_q  <= 1'b0;
          done_q <= 1'b0;
        end else if (start_i) begin
          a_q    <= a_i;
          b_q    <= blk_t'(b_i);
          acc_q  <= '0;
          cnt_q  <= '0;
          run_q  <= 1'b1;
          done_q <= 1'b0;
        end else if (run_q) begin
          acc_q <= acc_q ^ step_x;
          a_q   <= a_q >> STEP;
          b_q   <= b_q << STEP;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(ITERS - 1)) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          done_q <= 1'b0;
        end
      end

      assign prod_o = acc_q;
      assign done_o = done_q;
    end
  endgenerate
endmodule

// File: rtl/ghash_fold.sv
module ghash_fold
  import ghash_pkg::*;
(
  input  blk_t p_lo_i,
  input  blk_t p_hi_i,
  input  blk_t p_mid_i,
  output blk_t res_o
);
  pair_t lo, hi, mid;
  lane_t c0, c1, c2, c3;
  pair_t f1, f2;
  lane_t c1a, c2a, c2b, c3b;

  always_comb begin
    lo  = p_lo_i;
    hi  = p_hi_i;
    mid = p_mid_i ^ p_lo_i ^ p_hi_i;
    // 256-bit raw product as four lanes, c3 most significant
    c0 = lo.lo;
    c1 = lo.hi ^ mid.lo;
    c2 = hi.lo ^ mid.hi;
    c3 = hi.hi;
    // fold lowest lane upward
    f1  = clmul(c0, RED_K);
    c1a = c1 ^ f1.lo;
    c2a = c2 ^ f1.hi ^ c0;
    // fold the updated second lane
    f2  = clmul(c1a, RED_K);
    c2b = c2a ^ f2.lo;
    c3b = c3 ^ f2.hi ^ c1a;
  end

  assign res_o = {c3b, c2b};
endmodule

// File: rtl/ghash_karatsuba.sv
module ghash_karatsuba
  import ghash_pkg::*;
#(
  parameter bit          SERIAL = 1'b0,
  parameter int unsigned STEP   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               key_valid_i,
  output logic               key_ready_o,
  input  logic [BLK_W-1:0]   key_i,
  input  logic               blk_valid_i,
  output logic               blk_ready_o,
  input  logic [BLK_W-1:0]   blk_i,
  output logic [BLK_W-1:0]   acc_o,
  output logic               done_o
);
  logic  busy_q, key_ok_q, done_q;
  pair_t hkey_q;
  lane_t hsum_q;
  blk_t  acc_q;

  blk_t  tw_key;
  lane_t tw_sum;
  pair_t x_sum;
  logic  key_fire, blk_fire, all_done;
  blk_t  red;

  lane_t                op_a   [NUM_PROD];
  lane_t                op_b   [NUM_PROD];
  blk_t                 prod   [NUM_PROD];
  logic [NUM_PROD-1:0]  done_v;

  ghash_key_twist i_twist (
    .key_i   (key_i),
    .twist_o (tw_key),
    .sum_o   (tw_sum)
  );

  assign key_ready_o = ~busy_q;
  assign blk_ready_o = ~busy_q & key_ok_q & ~key_valid_i;
  assign key_fire    = key_valid_i & key_ready_o;
  assign blk_fire    = blk_valid_i & blk_ready_o;
  assign x_sum       = acc_q ^ blk_i;

  always_comb begin
    op_a[0] = x_sum.lo;          op_b[0] = hkey_q.lo;
    op_a[1] = x_sum.hi;          op_b[1] = hkey_q.hi;
    op_a[2] = x_sum.lo ^ x_sum.hi; op_b[2] = hsum_q;
  end

  generate
    for (genvar g = 0; g < int'(NUM_PROD); g++) begin : g_prod
      ghash_clmul_unit #(
        .SERIAL (SERIAL),
        .STEP   (STEP)
      ) i_unit (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (blk_fire),
        .a_i     (op_a[g]),
        .b_i     (op_b[g]),
        .done_o  (done_v[g]),
        .prod_o  (prod[g])
      );
    end
  endgenerate

  assign all_done = &done_v;

  ghash_fold i_fold (
    .p_lo_i  (prod[0]),
    .p_hi_i  (prod[1]),
    .p_mid_i (prod[2]),
    .res_o   (red)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      key_ok_q <= 1'b0;
      done_q   <= 1'b0;
      hkey_q   <= '0;
      hsum_q   <= '0;
      acc_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (key_fire) begin
        hkey_q   <= tw_key;
        hsum_q   <= tw_sum;
        key_ok_q <= 1'b1;
        acc_q    <= '0;
      end
      if (blk_fire) busy_q <= 1'b1;
      if (busy_q && all_done) begin
        acc_q  <= red;
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign acc_o  = acc_q;
  assign done_o = done_q;
endmodule

// File: rtl/ghash_karatsuba_chk.sv
module ghash_karatsuba_chk #(
  parameter bit          SERIAL = 1'b0,
  parameter int unsigned STEP   = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         key_valid_i,
  input logic         key_ready_o,
  input logic         blk_valid_i,
  input logic         blk_ready_o,
  input logic [127:0] acc_o,
  input logic         done_o
);
  // R7
  busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_valid_i && blk_ready_o) |=> (!key_ready_o && !blk_ready_o));

  // R8
  key_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_valid_i && key_ready_o) |-> !blk_ready_o);

  // R2
  key_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_valid_i && key_ready_o) |=> (acc_o == '0));

  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(acc_o) |-> (done_o || $past(key_valid_i && key_ready_o)));

  generate
    if (!SERIAL) begin : g_lat
      // R6
      done_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (blk_valid_i && blk_ready_o) |-> ##2 done_o);
    end
  endgenerate
endmodule

bind ghash_karatsuba ghash_karatsuba_chk #(.SERIAL(SERIAL), .STEP(STEP)) i_chk (.*);

// File: tb/test_ghash_karatsuba.sv
`timescale 1ns/1ps
module test_ghash_karatsuba;
  localparam bit          SERIAL = 1'b0;
  localparam int unsigned STEP   = 8;
  localparam int          LAT    = SERIAL ? (64 / STEP) + 1 : 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         key_valid = 1'b0;
  logic [127:0] key_data = '0;
  logic         blk_valid = 1'b0;
  logic [127:0] blk_data = '0;
  logic         key_ready, blk_ready, done;
  logic [127:0] acc;

  int checks = 0;
  int fails  = 0;
  bit mon_en = 1'b0;
  bit finished = 1'b0;

  logic [127:0] exp_acc = '0;
  logic         exp_done = 1'b0;
  logic [127:0] cur_key = '0;

  always #2.5 clk = ~clk;

  ghash_karatsuba #(.SERIAL(SERIAL), .STEP(STEP)) i_ghash_karatsuba (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .key_valid_i (key_valid),
    .key_ready_o (key_ready),
    .key_i       (key_data),
    .blk_valid_i (blk_valid),
    .blk_ready_o (blk_ready),
    .blk_i       (blk_data),
    .acc_o       (acc),
    .done_o      (done)
  );

  function automatic logic [127:0] gf_mul(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] z, v;
    z = '0;
    v = b;
    for (int i = 0; i < 128; i++) begin
      if (a[127-i]) z ^= v;
      v = v[0] ? ((v >> 1) ^ {8'hE1, 120'h0}) : (v >> 1);
    end
    return z;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, expv, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (mon_en && !finished) begin
      chk(acc == exp_acc, "R3 acc", acc, exp_acc);
      chk(done == exp_done, "R6 done", 128'(done), 128'(exp_done));
    end
  end

  task automatic load_key(input logic [127:0] h);
    @(negedge clk);
    key_valid = 1'b1;
    key_data  = h;
    while (!key_ready) @(negedge clk);
    @(posedge clk);
    cur_key = h;
    exp_acc = '0;
    #1 key_valid = 1'b0;
  endtask

  task automatic send_blk(input logic [127:0] d);
    logic [127:0] nxt;
    @(negedge clk);
    blk_valid = 1'b1;
    blk_data  = d;
    while (!blk_ready) @(negedge clk);
    @(posedge clk);
    nxt = gf_mul(exp_acc ^ d, cur_key);
    #1 blk_valid = 1'b0;
    repeat (LAT) @(posedge clk);
    exp_acc  = nxt;
    exp_done = 1'b1;
    @(posedge clk);
    exp_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] k, d, nxt;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(acc == '0, "R1 acc", acc, '0);
    chk(done == 1'b0, "R1 done", 128'(done), 0);
    chk(key_ready == 1'b1, "R1 key_ready", 128'(key_ready), 1);
    chk(blk_ready == 1'b0, "R1 blk_ready", 128'(blk_ready), 0);
    @(negedge clk);
    rst_n = 1'b1;
    mon_en = 1'b1;

    // R10 identity key, R2 clear on load
    load_key({1'b1, 127'h0});
    @(negedge clk);
    chk(acc == '0, "R2 cleared", acc, '0);
    send_blk(128'h0);
    chk(acc == '0, "R10 zero block", acc, '0);
    d = 128'h0123456789abcdef_fedcba9876543210;
    send_blk(d);
    @(negedge clk);
    chk(acc == d, "R10 identity", acc, d);

    // R4 key with bit 127 clear, R5 chain
    k = rnd128();
    k[127] = 1'b0;
    load_key(k);
    for (int i = 0; i < 6; i++) send_blk(rnd128());

    // R4 key with bit 127 set, R5 chain
    k = rnd128();
    k[127] = 1'b1;
    load_key(k);
    for (int i = 0; i < 6; i++) send_blk(rnd128());

    // R4 single-bit key extremes
    load_key(128'h1);
    send_blk(rnd128());
    send_blk({1'b1, 127'h0});

    // R7 key offered while a multiply is in flight
    d = rnd128();
    k = rnd128();
    @(negedge clk);
    blk_valid = 1'b1;
    blk_data  = d;
    @(posedge clk);
    nxt = gf_mul(exp_acc ^ d, cur_key);
    #1 blk_valid = 1'b0;
    key_valid = 1'b1;
    key_data  = k;
    repeat (LAT) begin
      @(negedge clk);
      chk(key_ready == 1'b0, "R7 key_ready busy", 128'(key_ready), 0);
      chk(blk_ready == 1'b0, "R7 blk_ready busy", 128'(blk_ready), 0);
      @(posedge clk);
    end
    exp_acc  = nxt;
    exp_done = 1'b1;
    @(posedge clk);
    exp_done = 1'b0;
    cur_key  = k;
    exp_acc  = '0;
    #1 key_valid = 1'b0;
    send_blk(rnd128());

    // R8 key and block offered together
    k = rnd128() | {1'b1, 127'h0};
    d = rnd128();
    @(negedge clk);
    key_valid = 1'b1;
    key_data  = k;
    blk_valid = 1'b1;
    blk_data  = d;
    #1;
    chk(blk_ready == 1'b0, "R8 blk_ready", 128'(blk_ready), 0);
    chk(key_ready == 1'b1, "R8 key_ready", 128'(key_ready), 1);
    @(posedge clk);
    cur_key = k;
    exp_acc = '0;
    #1 key_valid = 1'b0;
    @(posedge clk);
    nxt = gf_mul(d, cur_key);
    #1 blk_valid = 1'b0;
    repeat (LAT) @(posedge clk);
    exp_acc  = nxt;
    exp_done = 1'b1;
    @(posedge clk);
    exp_done = 1'b0;

    // R3 R5 random keys and chains
    for (int n = 0; n < 20; n++) begin
      k = rnd128();
      if (n % 2 == 0) k[127] = 1'b1;
      load_key(k);
      for (int j = 0; j < 3; j++) send_blk(rnd128());
    end

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule